// File: doc/BRIEF.md
# Branch Hazard Fetch Controller

This block is the front end of a four-stage in-order pipeline: fetch, decode, resolve, and a final completion stage. It owns the program counter and reads instruction memory through a combinational lookup outside the block. It tags every fetched slot with a 2-bit status that travels down the pipe with the slot. Branch direction and target are supplied by the resolve stage two cycles after the branch was fetched. The controller applies that outcome under one of three static policies:
- **Stall.** Fetch holds for two bubble cycles after every branch.
- **Fall-through prediction.** Fetch continues sequentially, and the two younger slots are squashed when the branch turns out taken.
- **Delayed branch.** The two slots after a branch always complete, and fetch is steered to the target only after them.

All three policies share the same resolve timing, so each one's cost shows up directly in the wasted-slot counter. A branch that lands in a delay slot has no defined meaning. The controller raises an error flag for it and does not act on it.

Top module: `branch_fetch_ctrl`

## Requirements
- R1: While `rst_n` is low, `fetch_pc_o` is 0 and `retire_valid_o`, `slot_err_o`, `res_valid_o` and both counters are 0. The first fetch, at address 0 with status 00, is presented in the cycle that follows the second rising clock edge after `rst_n` rises.
- R2: Slot status codes are 00 = valid, 01 = bubble, 10 = cancelled and 11 = delay slot. The program counter advances by 4 after each real fetch, and plain sequential code is fetched with status 00.
- R3: `res_valid_o` is high exactly two cycles after a live branch was fetched, with that branch's address on `res_pc_o`. When `br_taken_i` is high in that cycle, the next fetch is at `br_target_i`.
- R4: Mode 0 (code 3 behaves the same) is stall mode. The two fetch cycles after a branch are bubbles (status 01) with the program counter held, and the next real fetch is the target if taken or the fall-through address if not.
- R5: Mode 1 is fall-through prediction. After a branch, sequential fetch continues with status 00. A not-taken branch costs no slots.
- R6: In mode 1, a taken branch turns the two slots fetched after it into cancelled slots (status 10). Those slots never complete and never resolve as branches, even if they hold a branch.
- R7: Mode 2 is delayed branch. The two slots after a branch are fetched with status 11, are never cancelled and always complete. Redirection takes effect on the fetch right after them.
- R8: In mode 2, a branch fetched in a delay slot drives `slot_err_o` high for one cycle, in the cycle after its fetch. The controller does not treat that slot as a branch.
- R9: A slot with status 00 or 11 completes three cycles after its fetch, with `retire_valid_o` high and its address on `retire_pc_o`, in fetch order. Bubbles and cancelled slots never complete.
- R10: `cycle_cnt_o` counts clock cycles from the first fetch, starting at 0. `waste_cnt_o` counts bubble and cancelled slots as they leave the last stage.
- R11: `mode_i` is read continuously and is held constant outside reset. A mode applied during reset governs the whole following run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Branch policy: 0 stall, 1 fall-through prediction, 2 delayed, 3 as 0 |
| fetch_pc_o | output | AW | Address of the current fetch |
| fetch_stat_o | output | 2 | Status of the current fetch slot |
| imem_branch_i | input | 1 | Instruction at `fetch_pc_o` is a branch |
| res_valid_o | output | 1 | A live branch is in the resolve stage |
| res_pc_o | output | AW | Address of the slot in the resolve stage |
| br_taken_i | input | 1 | Resolved direction of the branch in the resolve stage |
| br_target_i | input | AW | Resolved target of the branch in the resolve stage |
| retire_valid_o | output | 1 | A slot completes this cycle |
| retire_pc_o | output | AW | Address of the slot in the last stage |
| retire_stat_o | output | 2 | Status of the slot in the last stage |
| slot_err_o | output | 1 | Previous fetch was a branch inside a delay slot |
| cycle_cnt_o | output | CW | Cycles since the first fetch |
| waste_cnt_o | output | CW | Bubble and cancelled slots drained |

## Verification
One short program is run under every mode code. It holds:
- a taken forward branch whose next slot is itself a branch;
- a not-taken branch;
- a branch two slots after that not-taken branch;
- a taken backward branch that loops the program.

Stall mode must lose exactly two slots per branch whatever the direction. Fall-through prediction must separate the free not-taken case from the two-slot taken case, and must not resolve the squashed branch. Delayed mode must complete both slots after every branch, and must raise the error flag for the two branches that sit in delay slots. A behavioural model predicts the fetch address, slot status, resolve, completion, error and counter values for every cycle, and the bench compares each of them against the ports.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [1:0] {
    ST_VALID  = 2'b00,
    ST_BUBBLE = 2'b01,
    ST_CANCEL = 2'b10,
    ST_DSLOT  = 2'b11
  } slot_stat_e;

  typedef enum logic [1:0] {
    POL_STALL = 2'd0,
    POL_PNT   = 2'd1,
    POL_DELAY = 2'd2,
    POL_RSVD  = 2'd3
  } br_policy_e;

  // distance in cycles between fetch of a branch and its resolution
  localparam int unsigned RESOLVE_DIST = 2;
  // byte step between sequential fetches
  localparam int unsigned PC_STEP      = 4;
  // stage count behind fetch: decode, resolve, completion
  localparam int unsigned PIPE_STAGES  = 3;
  localparam int unsigned RES_IDX      = RESOLVE_DIST - 1;
  localparam int unsigned RET_IDX      = PIPE_STAGES - 1;

endpackage

// File: rtl/fetch_rst_sync.sv
module fetch_rst_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  br_policy_e    pol_i,
  input  logic          imem_branch_i,
  input  logic          redir_i,
  input  logic [AW-1:0] redir_pc_i,
  output logic [AW-1:0] pc_o,
  output slot_stat_e    stat_o,
  output logic          isbr_o,
  output logic          err_o
);
  localparam logic [1:0] HAZ_LOAD = 2'(RESOLVE_DIST);

  logic [AW-1:0] pc_q, pc_d;
  logic [1:0]    hold_q, hold_d;
  logic [1:0]    dly_q, dly_d;
  logic          err_q, err_d;
  logic          fetching, in_dslot, pol_stall, pol_delay;
  logic          pc_en;

  assign pol_delay = (pol_i == POL_DELAY);
  assign pol_stall = (pol_i == POL_STALL) || (pol_i == POL_RSVD);

  // slot classification for the current fetch
  always_comb begin
    fetching = (hold_q == 2'd0);
    in_dslot = (dly_q != 2'd0);
    if (!fetching) begin
      stat_o = ST_BUBBLE;
    end else if (in_dslot) begin
      stat_o = ST_DSLOT;
    end else begin
      stat_o = ST_VALID;
    end
    isbr_o = fetching && !in_dslot && imem_branch_i;
    err_d  = fetching && in_dslot && imem_branch_i;
  end

  // next-state
  always_comb begin
    pc_en = redir_i || fetching;
    if (redir_i) begin
      pc_d = redir_pc_i;
    end else begin
      pc_d = pc_q + AW'(PC_STEP);
    end

    if (hold_q != 2'd0) begin
      hold_d = hold_q - 2'd1;
    end else if (isbr_o && pol_stall) begin
      hold_d = HAZ_LOAD;
    end else begin
      hold_d = 2'd0;
    end

    if (fetching && in_dslot) begin
      dly_d = dly_q - 2'd1;
    end else if (isbr_o && pol_delay) begin
      dly_d = HAZ_LOAD;
    end else begin
      dly_d = dly_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      hold_q <= 2'd0;
      dly_q  <= 2'd0;
      err_q  <= 1'b0;
    end else begin
      if (pc_en) begin
        pc_q <= pc_d;
      end
      hold_q <= hold_d;
      dly_q  <= dly_d;
      err_q  <= err_d;
    end
  end

  assign pc_o  = pc_q;
  assign err_o = err_q;

  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (isbr_o && pol_stall) |=> (stat_o == ST_BUBBLE)); // R4
  AST_ERR_FROM_DSLOT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($past(stat_o) == ST_DSLOT)); // R8
  AST_DSLOT_ONLY_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o == ST_DSLOT) |-> pol_delay); // R7
endmodule

// File: rtl/fetch_pipe.sv
module fetch_pipe
  import fetch_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] f_pc_i,
  input  slot_stat_e    f_stat_i,
  input  logic          f_isbr_i,
  input  logic          squash_i,
  output logic          res_valid_o,
  output logic [AW-1:0] res_pc_o,
  output logic          ret_occ_o,
  output slot_stat_e    ret_stat_o,
  output logic [AW-1:0] ret_pc_o
);
  logic            occ_q  [PIPE_STAGES];
  slot_stat_e      stat_q [PIPE_STAGES];
  logic [AW-1:0]   pc_q   [PIPE_STAGES];
  logic            isbr_q [RES_IDX+1];

  logic            occ_in  [PIPE_STAGES];
  slot_stat_e      stat_in [PIPE_STAGES];
  logic [AW-1:0]   pc_in   [PIPE_STAGES];

  // stage inputs: slots entering stages up to resolve are squashed on a taken prediction miss
  always_comb begin
    for (int s = 0; s < int'(PIPE_STAGES); s++) begin
      if (s == 0) begin
        occ_in[s]  = 1'b1;
        stat_in[s] = f_stat_i;
        pc_in[s]   = f_pc_i;
      end else begin
        occ_in[s]  = occ_q[s-1];
        stat_in[s] = stat_q[s-1];
        pc_in[s]   = pc_q[s-1];
      end
      if (squash_i && (s <= int'(RES_IDX))) begin
        stat_in[s] = ST_CANCEL;
      end
    end
  end

  for (genvar s = 0; s < int'(PIPE_STAGES); s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ_q[s]  <= 1'b0;
        stat_q[s] <= ST_BUBBLE;
        pc_q[s]   <= '0;
      end else begin
        occ_q[s]  <= occ_in[s];
        stat_q[s] <= stat_in[s];
        pc_q[s]   <= pc_in[s];
      end
    end
  end

  for (genvar s = 0; s <= int'(RES_IDX); s++) begin : g_brflag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        isbr_q[s] <= 1'b0;
      end else if (s == 0) begin
        isbr_q[s] <= f_isbr_i && !squash_i;
      end else begin
        isbr_q[s] <= isbr_q[s-1] && !squash_i;
      end
    end
  end

  assign res_valid_o = occ_q[RES_IDX] && isbr_q[RES_IDX];
  assign res_pc_o    = pc_q[RES_IDX];
  assign ret_occ_o   = occ_q[RET_IDX];
  assign ret_stat_o  = stat_q[RET_IDX];
  assign ret_pc_o    = pc_q[RET_IDX];

  AST_RES_NOT_CANCELLED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (stat_q[RES_IDX] != ST_CANCEL)); // R6
  AST_RETIRE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_occ_o |-> $past(occ_q[RET_IDX-1])); // R9
endmodule

// File: rtl/fetch_perf.sv
module fetch_perf
  import fetch_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_occ_i,
  input  slot_stat_e    ret_stat_i,
  output logic [CW-1:0] cycle_o,
  output logic [CW-1:0] waste_o
);
  logic [CW-1:0] cycle_q, waste_q;
  logic          waste_en;

  assign waste_en = ret_occ_i && ((ret_stat_i == ST_BUBBLE) || (ret_stat_i == ST_CANCEL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycle_q <= '0;
      waste_q <= '0;
    end else begin
      cycle_q <= cycle_q + CW'(1);
      if (waste_en) begin
        waste_q <= waste_q + CW'(1);
      end
    end
  end

  assign cycle_o = cycle_q;
  assign waste_o = waste_q;

  AST_WASTE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    waste_q <= cycle_q); // R10
  AST_WASTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !waste_en |=> $stable(waste_q)); // R10
endmodule

// File: rtl/branch_fetch_ctrl.sv
module branch_fetch_ctrl
  import fetch_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned CW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  output logic [AW-1:0] fetch_pc_o,
  output logic [1:0]    fetch_stat_o,
  input  logic          imem_branch_i,
  output logic          res_valid_o,
  output logic [AW-1:0] res_pc_o,
  input  logic          br_taken_i,
  input  logic [AW-1:0] br_target_i,
  output logic          retire_valid_o,
  output logic [AW-1:0] retire_pc_o,
  output logic [1:0]    retire_stat_o,
  output logic          slot_err_o,
  output logic [CW-1:0] cycle_cnt_o,
  output logic [CW-1:0] waste_cnt_o
);
  logic          rst_s_n;
  br_policy_e    pol;
  slot_stat_e    f_stat, r_stat;
  logic          f_isbr, redir, squash, r_occ;

  assign pol    = br_policy_e'(mode_i);
  assign redir  = res_valid_o && br_taken_i;
  assign squash = redir && (pol == POL_PNT);

  fetch_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  fetch_seq #(.AW(AW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .pol_i         (pol),
    .imem_branch_i (imem_branch_i),
    .redir_i       (redir),
    .redir_pc_i    (br_target_i),
    .pc_o          (fetch_pc_o),
    .stat_o        (f_stat),
    .isbr_o        (f_isbr),
    .err_o         (slot_err_o)
  );

  fetch_pipe #(.AW(AW)) u_pipe (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .f_pc_i      (fetch_pc_o),
    .f_stat_i    (f_stat),
    .f_isbr_i    (f_isbr),
    .squash_i    (squash),
    .res_valid_o (res_valid_o),
    .res_pc_o    (res_pc_o),
    .ret_occ_o   (r_occ),
    .ret_stat_o  (r_stat),
    .ret_pc_o    (retire_pc_o)
  );

  fetch_perf #(.CW(CW)) u_perf (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .ret_occ_i  (r_occ),
    .ret_stat_i (r_stat),
    .cycle_o    (cycle_cnt_o),
    .waste_o    (waste_cnt_o)
  );

  assign fetch_stat_o   = f_stat;
  assign retire_stat_o  = r_stat;
  assign retire_valid_o = r_occ && ((r_stat == ST_VALID) || (r_stat == ST_DSLOT));

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_s_n)
    $stable(mode_i)); // R11
  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_s_n)
    (res_valid_o && br_taken_i) |=> (fetch_pc_o == $past(br_target_i))); // R3
  AST_SQUASH_ONLY_PNT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (r_occ && (r_stat == ST_CANCEL)) |-> (pol == POL_PNT)); // R6
  AST_RETIRE_CLEAN: assert property (@(posedge clk) disable iff (!rst_s_n)
    retire_valid_o |-> (retire_stat_o != ST_BUBBLE) && (retire_stat_o != ST_CANCEL)); // R9
endmodule

// File: tb/tb_branch_fetch_ctrl.sv
`timescale 1ns/1ps
module tb_branch_fetch_ctrl;
  localparam int AW = 16;
  localparam int CW = 32;
  localparam int VAL = 0, BUB = 1, CAN = 2, DSL = 3;
  localparam int NCYC = 70;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [AW-1:0] fetch_pc, res_pc, br_target, retire_pc;
  logic [1:0]    fetch_stat, retire_stat;
  logic          imem_br, res_valid, br_taken, retire_valid, slot_err;
  logic [CW-1:0] cycle_cnt, waste_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  branch_fetch_ctrl #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .fetch_pc_o(fetch_pc), .fetch_stat_o(fetch_stat), .imem_branch_i(imem_br),
    .res_valid_o(res_valid), .res_pc_o(res_pc),
    .br_taken_i(br_taken), .br_target_i(br_target),
    .retire_valid_o(retire_valid), .retire_pc_o(retire_pc), .retire_stat_o(retire_stat),
    .slot_err_o(slot_err), .cycle_cnt_o(cycle_cnt), .waste_cnt_o(waste_cnt)
  );

  // test program: branch flags, directions and targets by address
  function automatic bit prog_br(input int a);
    return (a == 'h10) || (a == 'h14) || (a == 'h44) || (a == 'h4c) || (a == 'h6c);
  endfunction
  function automatic bit prog_taken(input int a);
    return (a == 'h10) || (a == 'h14) || (a == 'h4c) || (a == 'h6c);
  endfunction
  function automatic int prog_tgt(input int a);
    case (a)
      'h10:    return 'h40;
      'h14:    return 'h30;
      'h44:    return 'h80;
      'h4c:    return 'h60;
      default: return 'h00;
    endcase
  endfunction

  always_comb begin
    imem_br   = prog_br(int'(fetch_pc));
    br_taken  = prog_taken(int'(res_pc));
    br_target = AW'(prog_tgt(int'(res_pc)));
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int hpc  [NCYC];
  int hst  [NCYC];
  bit hbr  [NCYC];
  bit hbad [NCYC];

  task automatic run_mode(input int m);
    int  m_pc, hold, dly, wsum, st;
    bit  br, bad, rv;
    string pc_tag, st_tag;
    pc_tag = (m == 1) ? "R5" : (m == 2) ? "R7" : "R4";
    st_tag = (m == 1) ? "R6" : (m == 2) ? "R7" : "R2";
    rst_n = 1'b0;
    mode  = 2'(m);
    repeat (3) @(negedge clk);
    chk("R1", "reset fetch_pc", fetch_pc, 0);
    chk("R1", "reset retire_valid", retire_valid, 0);
    chk("R1", "reset res_valid", res_valid, 0);
    chk("R1", "reset slot_err", slot_err, 0);
    chk("R1", "reset cycle_cnt", cycle_cnt, 0);
    chk("R1", "reset waste_cnt", waste_cnt, 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    m_pc = 0; hold = 0; dly = 0; wsum = 0;
    for (int k = 0; k < NCYC; k++) begin
      @(negedge clk);
      if (hold > 0) begin
        st = BUB; br = 1'b0; bad = 1'b0;
      end else begin
        st  = (dly > 0) ? DSL : VAL;
        br  = prog_br(m_pc) && (dly == 0);
        bad = prog_br(m_pc) && (dly > 0);
      end
      hpc[k] = m_pc; hst[k] = st; hbr[k] = br; hbad[k] = bad;

      if (k == 0) chk("R1", "first fetch pc", fetch_pc, 0);
      chk(pc_tag, "fetch_pc", fetch_pc, m_pc);
      chk(st_tag, "fetch_stat", fetch_stat, st);
      chk("R10", "cycle_cnt", cycle_cnt, k);
      if (k == 5) chk("R11", "mode effect on stat", fetch_stat,
                      (m == 1) ? VAL : (m == 2) ? DSL : BUB);

      if (k >= 3) begin
        chk("R9", "retire_valid", retire_valid, (hst[k-3] == VAL) || (hst[k-3] == DSL));
        chk("R9", "retire_pc", retire_pc, hpc[k-3]);
      end else begin
        chk("R9", "retire_valid early", retire_valid, 0);
      end
      if (k >= 4 && (hst[k-4] == BUB || hst[k-4] == CAN)) wsum++;
      chk("R10", "waste_cnt", waste_cnt, wsum);

      rv = 1'b0;
      if (k >= 2) rv = hbr[k-2] && (hst[k-2] != CAN);
      chk("R3", "res_valid", res_valid, rv);
      if (rv) chk("R3", "res_pc", res_pc, hpc[k-2]);
      chk("R8", "slot_err", slot_err, (k >= 1) ? hbad[k-1] : 0);

      if (hold > 0) begin
        hold--;
      end else begin
        m_pc = (m_pc + 4) & 'hffff;
        if (dly > 0) dly--;
        if (br && (m == 0 || m == 3)) hold = 2;
        if (br && m == 2) dly = 2;
      end
      if (rv && prog_taken(hpc[k-2])) begin
        m_pc = prog_tgt(hpc[k-2]);
        if (m == 1) begin
          hst[k-1] = CAN;
          hst[k]   = CAN;
        end
      end
    end
  endtask

  initial begin
    for (int m = 0; m < 4; m++) run_mode(m);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule